// File: doc/BRIEF.md
# ATM Cell Transmit Processor

This block turns a stream of 53-byte ATM cells into the continuous payload byte stream that a SONET/SDH mapper consumes. Cells are written one byte per cycle into an internal store that holds eight complete cells. A start-of-cell flag marks the first byte of each cell. The downstream mapper pulls bytes with a request strobe. Each requested byte appears on the output one cycle later, and a marker flags the first byte of every cell.

On the way out, the fifth header octet can be replaced by a CRC-8 header check computed over the first four octets, with an optional coset pattern XORed onto it. The 48 information bytes can be scrambled with a self-synchronizing x^43 scrambler. The scrambler's state carries from cell to cell and is never touched by header octets. The mapper asks for bytes without regard to cell arrival. So whenever no complete cell is stored at a cell boundary, the block sends a fill cell. The fill cell takes its header and payload byte from configuration inputs.

Top module: `atm_cell_tx`

## Requirements
- R1: After reset, `out_valid` and `wr_ovf` are 0. A cell requested with nothing stored is a fill cell.
- R2: A byte requested by `rd_req` in one cycle appears on `out_data` with `out_valid` high in the next cycle, and `out_valid` is low in every other cycle. `out_soc` is high only on the first byte of each 53-byte output cell.
- R3: With `cfg_hec_ins` set, output octet 4 (counting from 0) is the CRC-8 of octets 0..3. The CRC uses generator x^8+x^2+x+1 (0x07), starts from 0, and takes bits MSB first.
- R4: With `cfg_coset` set, 0x55 is XORed onto the CRC before it is inserted. A fill header of 00 00 00 01 then yields 0x52.
- R5: With `cfg_hec_ins` clear, octet 4 of a stored cell leaves exactly as written. Fill cells always carry the computed header check.
- R6: With `cfg_scr_en` set, each bit of output octets 5..52 equals the input bit XOR the scrambled bit sent 43 payload bit-times earlier. Bits are taken MSB first, and the state starts at zero after reset. The state carries across cells and header octets do not advance it.
- R7: With `cfg_scr_en` clear, payload octets leave unchanged and the scrambler state is held. A later enable resumes from that held state.
- R8: A fill cell sends `cfg_idle_hdr[31:24]`, `[23:16]`, `[15:8]`, `[7:0]` as octets 0..3, then the header check, then 48 copies of `cfg_idle_pay`.
- R9: A stored cell becomes eligible to leave only after all 53 of its bytes are written. A partly written cell yields fill cells until it is complete.
- R10: The store holds eight cells. A cell that starts while eight are stored is dropped entirely and sets `wr_ovf`, which stays set until reset.
- R11: Stored cells leave in the order they were written. The decision between a stored cell and a fill cell is made at a cell boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write byte strobe |
| wr_sop | input | 1 | Marks the first byte of a written cell |
| wr_data | input | 8 | Written cell byte |
| rd_req | input | 1 | Mapper requests one payload byte |
| cfg_hec_ins | input | 1 | Replace octet 4 of stored cells with the computed check |
| cfg_coset | input | 1 | XOR 0x55 onto the computed check |
| cfg_scr_en | input | 1 | Scramble the 48 information bytes |
| cfg_idle_hdr | input | 32 | Fill-cell header octets 0..3 |
| cfg_idle_pay | input | 8 | Fill-cell payload byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_soc | output | 1 | Output byte is octet 0 of a cell |
| wr_ovf | output | 1 | Sticky: a cell was dropped for lack of room |

## Verification
The hardest state to reach from the ports is a full store with a new cell arriving. Reaching it means writing nine cells back to back with no requests at all. The eight kept cells must then be drained in order, and the next request must produce a fill cell. A second hard case is a partly written cell sitting at a cell boundary. The bench writes only its first 20 bytes and requests a cell, which must come out as fill. It then finishes the write and checks that the same cell comes out next. The scrambler's 43-bit memory spans cells. The bench therefore keeps its own bit-history model across cells, fill cells and periods with scrambling off, rather than checking each cell alone.

// File: rtl/atm_cell_tx.sv
module atm_cell_tx #(
  parameter int FIFO_CELLS = 8,
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 5,
  parameter int SCR_LEN    = 43,
  parameter logic [7:0] COSET = 8'h55
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sop,
  input  logic [7:0]  wr_data,
  input  logic        rd_req,
  input  logic        cfg_hec_ins,
  input  logic        cfg_coset,
  input  logic        cfg_scr_en,
  input  logic [31:0] cfg_idle_hdr,
  input  logic [7:0]  cfg_idle_pay,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_soc,
  output logic        wr_ovf
);
  localparam int DEPTH = FIFO_CELLS * CELL_BYTES;
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(FIFO_CELLS);
  localparam int CW = $clog2(CELL_BYTES + 1);
  localparam int NW = $clog2(FIFO_CELLS + 1);

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  logic [7:0]   mem [DEPTH];
  logic [SW-1:0] wslot, rslot;
  logic [CW-1:0] wcnt, rcnt;
  logic [NW-1:0] cells;
  logic          wdrop, use_idle;
  logic [7:0]    crc;
  logic [SCR_LEN-1:0] hist;

  // write side
  wire           full   = (cells == NW'(FIFO_CELLS));
  wire [CW-1:0]  widx   = wr_sop ? '0 : wcnt;
  wire           wr_ok  = wr_en && (wr_sop ? !full : (!wdrop && wcnt < CW'(CELL_BYTES)));
  wire           commit = wr_ok && (widx == CW'(CELL_BYTES - 1));

  // read side
  wire          rd_first = (rcnt == '0);
  wire          rd_last  = (rcnt == CW'(CELL_BYTES - 1));
  wire          src_idle = rd_first ? (cells == '0) : use_idle;
  wire          in_hdr   = (rcnt < CW'(HDR_BYTES - 1));
  wire          at_hec   = (rcnt == CW'(HDR_BYTES - 1));
  wire          pop      = rd_req && rd_last && !use_idle;
  wire [7:0]    fifo_b   = mem[AW'(rslot) * AW'(CELL_BYTES) + AW'(rcnt)];
  wire [7:0]    idle_b   = in_hdr ? cfg_idle_hdr[8*(3 - rcnt[1:0]) +: 8] : cfg_idle_pay;
  wire [7:0]    raw      = src_idle ? idle_b : fifo_b;
  wire [7:0]    hec      = crc ^ (cfg_coset ? COSET : 8'h00);

  logic [SCR_LEN-1:0] hist_nx;
  logic [7:0]         scr_b;
  always_comb begin
    hist_nx = hist;
    scr_b   = '0;
    for (int i = 7; i >= 0; i--) begin
      scr_b[i] = raw[i] ^ hist_nx[SCR_LEN-1];
      hist_nx  = {hist_nx[SCR_LEN-2:0], scr_b[i]};
    end
  end

  logic [7:0] byte_out;
  always_comb begin
    if (in_hdr)      byte_out = raw;
    else if (at_hec) byte_out = (src_idle || cfg_hec_ins) ? hec : raw;
    else             byte_out = cfg_scr_en ? scr_b : raw;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[AW'(wslot) * AW'(CELL_BYTES) + AW'(widx)] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wslot <= '0; rslot <= '0; wcnt <= CW'(CELL_BYTES); rcnt <= '0;
      cells <= '0; wdrop <= 1'b0; use_idle <= 1'b1; crc <= '0; hist <= '0;
      out_valid <= 1'b0; out_data <= '0; out_soc <= 1'b0; wr_ovf <= 1'b0;
    end else begin
      if (wr_en && wr_sop) begin
        wdrop <= full;
        if (full) wr_ovf <= 1'b1;
      end
      if (wr_ok) wcnt <= widx + 1'b1;
      if (commit) wslot <= (wslot == SW'(FIFO_CELLS - 1)) ? '0 : wslot + 1'b1;
      if (pop) rslot <= (rslot == SW'(FIFO_CELLS - 1)) ? '0 : rslot + 1'b1;
      cells <= cells + NW'(commit) - NW'(pop);

      out_valid <= rd_req;
      if (rd_req) begin
        out_data <= byte_out;
        out_soc  <= rd_first;
        rcnt     <= rd_last ? '0 : rcnt + 1'b1;
        if (rd_first) use_idle <= (cells == '0);
        if (in_hdr) crc <= crc8_step(rd_first ? 8'h00 : crc, raw);
        if (!in_hdr && !at_hec && cfg_scr_en) hist <= hist_nx;
      end else begin
        out_soc <= 1'b0;
      end
    end
  end

  // R2
  soc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) out_soc |-> out_valid);
  // R2
  soc_single_chk: assert property (@(posedge clk) disable iff (!rst_n) (out_soc && rd_req) |=> !out_soc);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ovf |=> wr_ovf);
  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cells <= NW'(FIFO_CELLS));
  // R9
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> cells != '0);
  // R7
  scr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !cfg_scr_en |=> $stable(hist));
endmodule

// File: tb/sim_atm_cell_tx.sv
module sim_atm_cell_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sop = 0, rd_req = 0;
  logic [7:0] wr_data = 0;
  logic cfg_hec_ins = 1, cfg_coset = 1, cfg_scr_en = 0;
  logic [31:0] cfg_idle_hdr = 32'h0000_0001;
  logic [7:0] cfg_idle_pay = 8'h6A;
  logic out_valid, out_soc, wr_ovf;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  atm_cell_tx u0 (.clk, .rst_n, .wr_en, .wr_sop, .wr_data, .rd_req, .cfg_hec_ins,
    .cfg_coset, .cfg_scr_en, .cfg_idle_hdr, .cfg_idle_pay, .out_valid, .out_data,
    .out_soc, .wr_ovf);

  int checks = 0, fails = 0;
  int q[$];
  bit sbits[$];
  logic [7:0] got [53];
  logic [7:0] expb [53];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp); end
  endtask

  function automatic logic [7:0] gen(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [39:0] v = {h, 8'h00};
    for (int i = 39; i >= 8; i--) if (v[i]) v[i -: 9] = v[i -: 9] ^ 9'h107;
    return v[7:0];
  endfunction

  function automatic logic [7:0] scr_model(input logic [7:0] d);
    logic [7:0] s;
    for (int i = 7; i >= 0; i--) begin
      s[i] = d[i] ^ sbits[sbits.size() - 43];
      sbits.push_back(s[i]);
    end
    return s;
  endfunction

  task automatic write_part(input int seed, input int from, input int upto);
    for (int i = from; i <= upto; i++) begin
      @(negedge clk); wr_en = 1; wr_sop = (i == 0); wr_data = gen(seed, i);
    end
    @(negedge clk); wr_en = 0; wr_sop = 0;
  endtask

  task automatic read_cell(input string req);
    bit idle = (q.size() == 0);
    int seed = idle ? 0 : q.pop_front();
    logic [31:0] h;
    int bad = -1, vbad = 0;
    h = idle ? cfg_idle_hdr : {gen(seed,0), gen(seed,1), gen(seed,2), gen(seed,3)};
    for (int i = 0; i < 4; i++) expb[i] = h[31 - 8*i -: 8];
    expb[4] = (idle || cfg_hec_ins) ? (ref_hec(h) ^ (cfg_coset ? 8'h55 : 8'h00)) : gen(seed, 4);
    for (int i = 5; i < 53; i++) begin
      expb[i] = idle ? cfg_idle_pay : gen(seed, i);
      if (cfg_scr_en) expb[i] = scr_model(expb[i]);
    end
    for (int i = 0; i < 53; i++) begin
      @(negedge clk); rd_req = 1;
      @(negedge clk); rd_req = 0;
      got[i] = out_data;
      if (!out_valid || out_soc != (i == 0)) vbad++;
      if (bad < 0 && out_data !== expb[i]) bad = i;
    end
    check(vbad == 0, "R2 valid/soc", vbad, 0);
    @(negedge clk);
    check(out_valid == 0, "R2 idle valid", out_valid, 0);
    if (bad < 0) check(1, req, 0, 0);
    else begin
      $display("  byte %0d of cell", bad);
      check(0, req, got[bad], expb[bad]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 43; i++) sbits.push_back(1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 0 && wr_ovf == 0, "R1 reset", {out_valid, wr_ovf}, 0);
    // R1 R8 R4 fill cell with 00 00 00 01 and coset
    read_cell("R1 R8 fill cell");
    check(got[4] == 8'h52, "R4 fill hec", got[4], 8'h52);
    cfg_idle_hdr = 32'h0000_0000; cfg_idle_pay = 8'h00; cfg_coset = 0;
    read_cell("R8 unassigned-style fill");
    // R3 header check sweep, coset off then on
    for (int c = 0; c < 2; c++) begin
      cfg_coset = c[0];
      for (int s = 1; s <= 24; s++) begin
        write_part(s * 7 + c, 0, 52); q.push_back(s * 7 + c);
        read_cell(c ? "R4 coset hec" : "R3 crc hec");
      end
    end
    // R5 pass-through
    cfg_hec_ins = 0;
    write_part(99, 0, 52); q.push_back(99);
    read_cell("R5 octet4 pass");
    check(got[4] == gen(99, 4), "R5 raw octet4", got[4], gen(99, 4));
    read_cell("R5 fill keeps hec");
    cfg_hec_ins = 1;
    // R6 R7 scrambler across cells
    cfg_scr_en = 1; cfg_idle_pay = 8'hA5;
    for (int s = 0; s < 3; s++) begin
      write_part(200 + s, 0, 52); q.push_back(200 + s);
      read_cell("R6 scrambled");
    end
    read_cell("R6 scrambled fill");
    cfg_scr_en = 0;
    write_part(210, 0, 52); q.push_back(210);
    read_cell("R7 scr off");
    cfg_scr_en = 1;
    write_part(211, 0, 52); q.push_back(211);
    read_cell("R7 resume");
    cfg_scr_en = 0;
    // R9 partial cell
    write_part(300, 0, 19);
    read_cell("R9 partial gives fill");
    write_part(300, 20, 52); q.push_back(300);
    read_cell("R9 completed cell");
    // R10 R11 overflow and order
    for (int s = 0; s < 9; s++) begin
      write_part(400 + s, 0, 52);
      if (s < 8) q.push_back(400 + s);
    end
    check(wr_ovf == 1, "R10 overflow flag", wr_ovf, 1);
    for (int s = 0; s < 8; s++) read_cell("R11 order");
    read_cell("R10 ninth dropped");
    check(wr_ovf == 1, "R10 sticky", wr_ovf, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule